// File: doc/BRIEF.md
# Storage Controller State-Change Event Capture

This block follows the configuration writes made to each of up to 256 storage controller functions. It turns them into sticky per-controller events. Each function carries an enable bit and a two-bit shutdown field. A write that raises the enable bit records an "enabled" event, and a write that drops it records a "reset" event. A shutdown code of 01 records a normal shutdown and a code of 10 records an abrupt shutdown. A separate pulse input records a function-level reset for one function. Each event type has a 256-bit vector holding one bit per controller.

Software reads the vectors through a simple word-addressed register port. It clears the enable, reset and shutdown vectors by writing ones to them. The function-level-reset vector is read-only, so software clears one of its bits by writing a command word that holds the function ID and a clear opcode. A global status word carries one summary bit per event type. Each summary bit is set while any bit of its vector is set, and it cannot be cleared directly. A bitwise enable mask over the status word drives one registered interrupt line.

Register word addresses are `reg_addr[5:3]` as a group and `reg_addr[2:0]` as a word within the group. Group 0 holds the global words: word 0 is status, word 1 is the interrupt enable mask, and word 2 is the function-reset clear command. Groups 2, 3, 4, 5 and 6 hold the enabled, reset, normal-shutdown, abrupt-shutdown and function-reset vectors. Word w of a group covers functions 32w to 32w+31, and function f sits at bit f mod 32.

Top module: `ctrl_evt_capture`

## Requirements
- R1: A `cfg_vld` write with `cfg_en`=1 to a function whose stored enable bit is 0 sets that function's bit in the enabled vector (group 2) on the same clock edge.
- R2: A `cfg_vld` write with `cfg_en`=0 to a function whose stored enable bit is 1 sets that function's bit in the reset vector (group 3). A write that leaves the enable bit unchanged records neither an enabled nor a reset event.
- R3: A write whose shutdown code differs from the function's stored code sets the normal-shutdown bit (group 4) when the code is 2'b01, and the abrupt-shutdown bit (group 5) when the code is 2'b10. Codes 2'b00 and 2'b11 record nothing, and rewriting the stored code again records nothing.
- R4: A register write to a word of groups 2 to 5 clears exactly the vector bits where the write data is 1. Bits written with 0 keep their value.
- R5: When an event set and a clear reach the same vector bit in the same cycle, the bit ends up set.
- R6: Status word bits 0 to 4 (enabled, reset, normal shutdown, abrupt shutdown, function reset) read as 1 exactly when any bit of the matching vector is set. Writes to the status word have no effect, and unmapped addresses read as zero.
- R7: A `flr_vld` pulse sets the function-reset bit of `flr_fid` (group 6). That bit clears only on a write to global word 2 with the function ID in bits [7:0] and opcode 4'h0 in bits [19:16]. Other opcodes, and writes to group 6, change nothing.
- R8: Global word 1 bits [4:0] form a read/write mask over the status bits. `irq` is 1 in the cycle after a cycle in which (status AND mask) is non-zero, and 0 otherwise.
- R9: After reset, all vectors, the mask and `irq` are zero, and every function's stored enable bit and shutdown code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_vld | input | 1 | A configuration write for one function is present |
| cfg_fid | input | 8 | Function ID of the configuration write |
| cfg_en | input | 1 | New enable bit of that function |
| cfg_shn | input | 2 | New shutdown code of that function |
| flr_vld | input | 1 | Function-level reset received |
| flr_fid | input | 8 | Function ID of the function-level reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address (group, word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check four things. Each enable, reset and function-reset event lands in its vector on the next edge. No vector bit ever falls unless a clearing write to its own group or the clear command arrived. Normal and abrupt shutdown are never raised together, and a summary bit only rises after a matching event. They also track the interrupt line against the masked status from one cycle earlier. Only the bench scenarios can show the rest: the register word and bit layout, the suppression of repeated or neutral shutdown codes, set-over-clear when a write and an event collide, the opcode filtering of the function-reset clear, and that writes to read-only words change nothing.

// File: rtl/ctrl_evt_pkg.sv
package ctrl_evt_pkg;

  // event type indices; also the status bit positions
  localparam int EV_EN   = 0;
  localparam int EV_RST  = 1;
  localparam int EV_NSHN = 2;
  localparam int EV_ASHN = 3;
  localparam int EV_FLR  = 4;
  localparam int NUM_EV  = 5;

  // address groups
  localparam int          GRP_W    = 3;
  localparam logic [2:0]  GRP_GLB  = 3'd0;
  localparam logic [2:0]  GRP_VEC0 = 3'd2;  // event i lives in group GRP_VEC0 + i

  // global words
  localparam int WORD_STS     = 0;
  localparam int WORD_IE      = 1;
  localparam int WORD_FLR_CMD = 2;

  // function-reset clear command fields
  localparam int         OPC_LSB    = 16;
  localparam int         OPC_W      = 4;
  localparam logic [3:0] OPC_FLR_CLR = 4'h0;

  // shutdown codes
  localparam logic [1:0] SHN_NORMAL = 2'b01;
  localparam logic [1:0] SHN_ABRUPT = 2'b10;

endpackage

// File: rtl/ctrl_rst_sync.sv
module ctrl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ctrl_cfg_tracker.sv
module ctrl_cfg_tracker
  import ctrl_evt_pkg::*;
#(
  parameter int N_FUNC = 256,
  parameter int FID_W  = $clog2(N_FUNC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_vld,
  input  logic [FID_W-1:0] cfg_fid,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_shn,
  output logic             ev_en,
  output logic             ev_rst,
  output logic             ev_nshn,
  output logic             ev_ashn
);

  logic [N_FUNC-1:0]       en_q, en_d;
  logic [N_FUNC-1:0][1:0]  shn_q, shn_d;
  logic                    prev_en;
  logic [1:0]              prev_shn;

  // event detection against the stored per-function state
  always_comb begin
    prev_en  = en_q[cfg_fid];
    prev_shn = shn_q[cfg_fid];
    ev_en    = cfg_vld &  cfg_en & ~prev_en;
    ev_rst   = cfg_vld & ~cfg_en &  prev_en;
    ev_nshn  = cfg_vld && (cfg_shn == SHN_NORMAL) && (prev_shn != SHN_NORMAL);
    ev_ashn  = cfg_vld && (cfg_shn == SHN_ABRUPT) && (prev_shn != SHN_ABRUPT);
  end

  // next state
  always_comb begin
    en_d  = en_q;
    shn_d = shn_q;
    if (cfg_vld) begin
      en_d[cfg_fid]  = cfg_en;
      shn_d[cfg_fid] = cfg_shn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      shn_q <= '0;
    end else if (cfg_vld) begin
      en_q  <= en_d;
      shn_q <= shn_d;
    end
  end

endmodule

// File: rtl/ctrl_sticky_vec.sv
module ctrl_sticky_vec #(
  parameter int N     = 256,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_vld,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [N-1:0]     clr_mask,
  output logic [N-1:0]     vec
);

  logic [N-1:0] vec_q, vec_d, set_mask;
  logic         upd;

  always_comb begin
    set_mask = '0;
    if (set_vld) begin
      set_mask[set_idx] = 1'b1;
    end
    // set has priority over a clear of the same bit
    vec_d = (vec_q & ~clr_mask) | set_mask;
    upd   = set_vld | (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (upd) begin
      vec_q <= vec_d;
    end
  end

  assign vec = vec_q;

endmodule

// File: rtl/ctrl_evt_regs.sv
module ctrl_evt_regs
  import ctrl_evt_pkg::*;
#(
  parameter int N_FUNC = 256,
  parameter int DW     = 32,
  localparam int WORDS  = N_FUNC / DW,
  localparam int WORD_W = $clog2(WORDS),
  localparam int ADDR_W = WORD_W + GRP_W,
  localparam int FID_W  = $clog2(N_FUNC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DW-1:0]                 reg_wdata,
  output logic [DW-1:0]                 reg_rdata,
  input  logic [NUM_EV-1:0][N_FUNC-1:0] vecs,
  output logic [NUM_EV-1:0][N_FUNC-1:0] clr_masks,
  output logic [NUM_EV-1:0]             status,
  output logic [NUM_EV-1:0]             ie,
  output logic                          irq
);

  logic [GRP_W-1:0]  grp;
  logic [WORD_W-1:0] word;
  logic              glb_sel;
  logic              ie_we;
  logic [NUM_EV-1:0] ie_q, ie_d;
  logic              irq_q, irq_d;
  logic              flr_cmd_clr;

  assign grp     = reg_addr[ADDR_W-1:WORD_W];
  assign word    = reg_addr[WORD_W-1:0];
  assign glb_sel = (grp == GRP_GLB);

  // summary bits: any bit of each vector
  always_comb begin
    for (int i = 0; i < NUM_EV; i++) begin
      status[i] = |vecs[i];
    end
  end

  // clear masks
  assign flr_cmd_clr = reg_wr && glb_sel && (word == WORD_W'(WORD_FLR_CMD)) &&
                       (reg_wdata[OPC_LSB +: OPC_W] == OPC_FLR_CLR);

  always_comb begin
    clr_masks = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (i != EV_FLR && reg_wr && (grp == GRP_VEC0 + GRP_W'(i))) begin
        clr_masks[i][int'(word)*DW +: DW] = reg_wdata;
      end
    end
    if (flr_cmd_clr) begin
      clr_masks[EV_FLR][reg_wdata[FID_W-1:0]] = 1'b1;
    end
  end

  // interrupt enable mask
  assign ie_we = reg_wr && glb_sel && (word == WORD_W'(WORD_IE));

  always_comb begin
    ie_d = ie_q;
    if (ie_we) begin
      ie_d = reg_wdata[NUM_EV-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else if (ie_we) begin
      ie_q <= ie_d;
    end
  end

  // registered interrupt
  assign irq_d = |(status & ie_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (glb_sel) begin
      if (word == WORD_W'(WORD_STS)) begin
        reg_rdata[NUM_EV-1:0] = status;
      end else if (word == WORD_W'(WORD_IE)) begin
        reg_rdata[NUM_EV-1:0] = ie_q;
      end
    end else begin
      for (int i = 0; i < NUM_EV; i++) begin
        if (grp == GRP_VEC0 + GRP_W'(i)) begin
          reg_rdata = vecs[i][int'(word)*DW +: DW];
        end
      end
    end
  end

  assign ie  = ie_q;
  assign irq = irq_q;

endmodule

// File: rtl/ctrl_evt_capture.sv
module ctrl_evt_capture
  import ctrl_evt_pkg::*;
#(
  parameter int N_FUNC = 256,
  parameter int DW     = 32,
  localparam int FID_W  = $clog2(N_FUNC),
  localparam int ADDR_W = $clog2(N_FUNC / DW) + GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_vld,
  input  logic [FID_W-1:0]  cfg_fid,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_shn,
  input  logic              flr_vld,
  input  logic [FID_W-1:0]  flr_fid,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);

  logic                          rst_sync_n;
  logic [NUM_EV-1:0]             ev_set;
  logic [NUM_EV-1:0][FID_W-1:0]  ev_fid;
  logic [NUM_EV-1:0][N_FUNC-1:0] vecs;
  logic [NUM_EV-1:0][N_FUNC-1:0] clr_masks;
  logic [NUM_EV-1:0]             status;
  logic [NUM_EV-1:0]             ie;

  ctrl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ctrl_cfg_tracker #(.N_FUNC(N_FUNC), .FID_W(FID_W)) u_tracker (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg_vld (cfg_vld),
    .cfg_fid (cfg_fid),
    .cfg_en  (cfg_en),
    .cfg_shn (cfg_shn),
    .ev_en   (ev_set[EV_EN]),
    .ev_rst  (ev_set[EV_RST]),
    .ev_nshn (ev_set[EV_NSHN]),
    .ev_ashn (ev_set[EV_ASHN])
  );

  assign ev_set[EV_FLR] = flr_vld;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_vec
    if (g == EV_FLR) begin : g_flr
      assign ev_fid[g] = flr_fid;
    end else begin : g_cfg
      assign ev_fid[g] = cfg_fid;
    end
    ctrl_sticky_vec #(.N(N_FUNC), .IDX_W(FID_W)) u_vec (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .set_vld  (ev_set[g]),
      .set_idx  (ev_fid[g]),
      .clr_mask (clr_masks[g]),
      .vec      (vecs[g])
    );
  end

  ctrl_evt_regs #(.N_FUNC(N_FUNC), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .vecs      (vecs),
    .clr_masks (clr_masks),
    .status    (status),
    .ie        (ie),
    .irq       (irq)
  );

endmodule

// File: rtl/ctrl_evt_capture_chk.sv
module ctrl_evt_capture_chk
  import ctrl_evt_pkg::*;
#(
  parameter int N_FUNC = 256,
  parameter int DW     = 32,
  localparam int FID_W  = $clog2(N_FUNC),
  localparam int WORD_W = $clog2(N_FUNC / DW),
  localparam int ADDR_W = WORD_W + GRP_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [DW-1:0]                 reg_wdata,
  input logic [NUM_EV-1:0]             ev_set,
  input logic [FID_W-1:0]              cfg_fid,
  input logic [FID_W-1:0]              flr_fid,
  input logic [NUM_EV-1:0][N_FUNC-1:0] vecs,
  input logic [NUM_EV-1:0]             status,
  input logic [NUM_EV-1:0]             ie,
  input logic                          irq
);

  logic [GRP_W-1:0] grp;
  logic             flr_clr_cmd;

  assign grp         = reg_addr[ADDR_W-1:WORD_W];
  assign flr_clr_cmd = reg_wr && (grp == GRP_GLB) &&
                       (reg_addr[WORD_W-1:0] == WORD_W'(WORD_FLR_CMD)) &&
                       (reg_wdata[OPC_LSB +: OPC_W] == OPC_FLR_CLR);

  p_en_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[EV_EN] |=> vecs[EV_EN][$past(cfg_fid)]);

  p_rst_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[EV_RST] |=> vecs[EV_RST][$past(cfg_fid)]);

  p_en_rst_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_set[EV_EN] && ev_set[EV_RST]));

  p_shn_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_set[EV_ASHN:EV_NSHN]));

  for (genvar g = 0; g < EV_FLR; g++) begin : g_hold
    p_no_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && (grp == GRP_VEC0 + GRP_W'(g))) |=>
        (($past(vecs[g]) & ~vecs[g]) == '0));
  end

  p_status_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) && ($past(status) == '0) |-> ($past(ev_set) != '0));

  p_flr_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[EV_FLR] |=> vecs[EV_FLR][$past(flr_fid)]);

  p_flr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flr_clr_cmd |=> (($past(vecs[EV_FLR]) & ~vecs[EV_FLR]) == '0));

  p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ie) != '0) |=> irq);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ie) == '0) |=> !irq);

endmodule

bind ctrl_evt_capture ctrl_evt_capture_chk #(.N_FUNC(N_FUNC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ev_set    (ev_set),
  .cfg_fid   (cfg_fid),
  .flr_fid   (flr_fid),
  .vecs      (vecs),
  .status    (status),
  .ie        (ie),
  .irq       (irq)
);

// File: tb/ctrl_evt_capture_tb.sv
`timescale 1ns/1ps
module ctrl_evt_capture_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_vld;
  logic [7:0]  cfg_fid;
  logic        cfg_en;
  logic [1:0]  cfg_shn;
  logic        flr_vld;
  logic [7:0]  flr_fid;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  ctrl_evt_capture u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_vld(cfg_vld), .cfg_fid(cfg_fid), .cfg_en(cfg_en), .cfg_shn(cfg_shn),
    .flr_vld(flr_vld), .flr_fid(flr_fid),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;

  // reference model
  bit         m_en  [256];
  bit [1:0]   m_shn [256];
  bit [255:0] m_vec [5];
  bit [4:0]   m_ie;

  function automatic bit [4:0] exp_status();
    bit [4:0] s;
    for (int i = 0; i < 5; i++) s[i] = |m_vec[i];
    return s;
  endfunction

  function automatic bit [31:0] exp_read(input bit [5:0] a);
    bit [2:0] g = a[5:3];
    bit [2:0] w = a[2:0];
    if (g == 3'd0) begin
      if (w == 3'd0) return {27'd0, exp_status()};
      if (w == 3'd1) return {27'd0, m_ie};
      return 32'd0;
    end
    if (g >= 3'd2 && g <= 3'd6) return m_vec[g-2][int'(w)*32 +: 32];
    return 32'd0;
  endfunction

  function automatic string grp_tag(input bit [5:0] a);
    case (a[5:3])
      3'd2: return "R1";
      3'd3: return "R2";
      3'd4, 3'd5: return "R3";
      3'd6: return "R7";
      3'd0: return (a[2:0] == 3'd1) ? "R8" : "R6";
      default: return "R6";
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input bit [31:0] act, input bit [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    cfg_vld = 0; cfg_fid = 0; cfg_en = 0; cfg_shn = 0;
    flr_vld = 0; flr_fid = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic rd_chk(input bit [5:0] a, input string tag);
    reg_wr = 0; reg_addr = a;
    #1;
    cmp(tag, $sformatf("read addr %h", a), reg_rdata, exp_read(a));
  endtask

  // one clock: model follows the requirements, irq checked against the previous state (R8)
  task automatic step();
    bit         exp_irq;
    bit [255:0] setm [5];
    bit [255:0] clrm [5];
    exp_irq = |(exp_status() & m_ie);
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin setm[i] = '0; clrm[i] = '0; end
    if (cfg_vld) begin
      if (cfg_en && !m_en[cfg_fid]) setm[0][cfg_fid] = 1;
      if (!cfg_en && m_en[cfg_fid]) setm[1][cfg_fid] = 1;
      if (cfg_shn != m_shn[cfg_fid] && cfg_shn == 2'b01) setm[2][cfg_fid] = 1;
      if (cfg_shn != m_shn[cfg_fid] && cfg_shn == 2'b10) setm[3][cfg_fid] = 1;
      m_en[cfg_fid]  = cfg_en;
      m_shn[cfg_fid] = cfg_shn;
    end
    if (flr_vld) setm[4][flr_fid] = 1;
    if (reg_wr) begin
      if (reg_addr[5:3] >= 3'd2 && reg_addr[5:3] <= 3'd5)
        clrm[reg_addr[5:3]-2][int'(reg_addr[2:0])*32 +: 32] = reg_wdata;
      if (reg_addr == 6'd2 && reg_wdata[19:16] == 4'h0) clrm[4][reg_wdata[7:0]] = 1;
      if (reg_addr == 6'd1) m_ie = reg_wdata[4:0];
    end
    for (int i = 0; i < 5; i++) m_vec[i] = (m_vec[i] & ~clrm[i]) | setm[i];
    #1;
    cmp("R8", "irq", {31'd0, irq}, {31'd0, exp_irq});
    idle();
  endtask

  task automatic cfg_op(input bit [7:0] f, input bit en, input bit [1:0] shn);
    cfg_vld = 1; cfg_fid = f; cfg_en = en; cfg_shn = shn;
  endtask

  task automatic wr_op(input bit [5:0] a, input bit [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    for (int i = 0; i < 256; i++) begin m_en[i] = 0; m_shn[i] = 0; end
    for (int i = 0; i < 5; i++) m_vec[i] = '0;
    m_ie = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R9 reset state
    cmp("R9", "irq after reset", {31'd0, irq}, 32'd0);
    reg_addr = 6'd0; #1;
    cmp("R9", "status after reset", reg_rdata, 32'd0);
    reg_addr = 6'h10; #1;
    cmp("R9", "enabled word0 after reset", reg_rdata, 32'd0);

    wr_op(6'd1, 32'h1f); step();
    rd_chk(6'd1, "R8");

    // R1 rise, R2 fall
    cfg_op(8'd0, 1, 2'b00); step();
    reg_addr = 6'h10; #1;
    cmp("R1", "enabled bit0", reg_rdata, 32'h1);
    rd_chk(6'd0, "R6");
    cfg_op(8'd0, 1, 2'b00); step();          // no change: no event
    rd_chk(6'h18, "R2");
    cfg_op(8'd0, 0, 2'b00); step();
    reg_addr = 6'h18; #1;
    cmp("R2", "reset bit0", reg_rdata, 32'h1);

    // R3 shutdown codes on function 255
    cfg_op(8'd255, 0, 2'b01); step();
    reg_addr = 6'h27; #1;
    cmp("R3", "normal shutdown fn255", reg_rdata, 32'h8000_0000);
    wr_op(6'h27, 32'h8000_0000); step();
    reg_addr = 6'h27; #1;
    cmp("R4", "w1c cleared fn255", reg_rdata, 32'h0);
    cfg_op(8'd255, 0, 2'b01); step();        // same code again
    reg_addr = 6'h27; #1;
    cmp("R3", "repeat code no event", reg_rdata, 32'h0);
    cfg_op(8'd255, 0, 2'b11); step();
    rd_chk(6'h27, "R3"); rd_chk(6'h2f, "R3");
    cfg_op(8'd255, 0, 2'b10); step();
    reg_addr = 6'h2f; #1;
    cmp("R3", "abrupt shutdown fn255", reg_rdata, 32'h8000_0000);

    // R5 set beats clear in same cycle
    cfg_op(8'd1, 1, 2'b00); wr_op(6'h10, 32'h3); step();
    reg_addr = 6'h10; #1;
    cmp("R5", "set wins bit1, bit0 cleared", reg_rdata, 32'h2);

    // R6 status write ignored
    wr_op(6'd0, 32'hffff_ffff); step();
    rd_chk(6'd0, "R6");
    rd_chk(6'h3f, "R6");

    // R7 function reset
    flr_vld = 1; flr_fid = 8'd40; step();
    reg_addr = 6'h31; #1;
    cmp("R7", "flr fn40 set", reg_rdata, 32'h100);
    wr_op(6'h31, 32'hffff_ffff); step();
    rd_chk(6'h31, "R7");
    wr_op(6'd2, 32'h0001_0028); step();       // opcode 1
    reg_addr = 6'h31; #1;
    cmp("R7", "nonzero opcode ignored", reg_rdata, 32'h100);
    flr_vld = 1; flr_fid = 8'd40; wr_op(6'd2, 32'h0000_0028); step();
    reg_addr = 6'h31; #1;
    cmp("R5", "flr set wins over clear", reg_rdata, 32'h100);
    wr_op(6'd2, 32'h0000_0028); step();
    reg_addr = 6'h31; #1;
    cmp("R7", "opcode 0 clears fn40", reg_rdata, 32'h0);

    // R8 mask off
    wr_op(6'd1, 32'h0); step();
    step();
    rd_chk(6'd1, "R8");

    // constrained random
    for (int it = 0; it < 4000; it++) begin
      bit [5:0] ra;
      int op;
      ra = 6'($urandom % 64);
      rd_chk(ra, grp_tag(ra));
      if ($urandom % 3 != 0) begin
        cfg_vld = 1;
        cfg_fid = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 8);
        cfg_en  = 1'($urandom);
        cfg_shn = 2'($urandom);
      end
      if ($urandom % 6 == 0) begin
        flr_vld = 1;
        flr_fid = 8'($urandom % 8);
      end
      op = int'($urandom % 8);
      case (op)
        0: wr_op({3'($urandom % 5 + 2), 3'($urandom % 2)},
                 ($urandom % 2 == 0) ? 32'($urandom) : 32'hffff_ffff);
        1: wr_op(6'd2, {12'd0, ($urandom % 3 == 0) ? 4'($urandom) : 4'h0,
                        8'd0, 8'($urandom % 8)});
        2: wr_op(6'd1, 32'($urandom));
        3: wr_op(6'd0, 32'($urandom));
        default: ;
      endcase
      step();
    end

    for (int a = 0; a < 64; a++) rd_chk(6'(a), grp_tag(6'(a)));

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule